// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire serial bus that fronts a byte-wide storage array kept inside the design. A fast system clock oversamples the clock and data lines. The block finds START and STOP conditions on the sampled lines and claims the bus when the header byte matches its device type and three strap inputs. It drives the data line only through an open-drain pull-low enable. A bus master sets a two-byte word address and then writes one byte or a run of bytes, or reads from the current address or from a given address. A read keeps going for as long as the master acknowledges each byte.

Write data is held in a page buffer and reaches the array only when the master ends the transfer with a STOP at a byte boundary. After that, the block is busy for a write time set in system clocks. While it is busy it does not acknowledge its own header, so the master can poll for completion. A write-protect input lets the transfer proceed and be acknowledged, but throws the buffered page away. The array size is set by a parameter. The default is kept small, and a value of 15 gives the full 32,768-byte array.

Top module: `eeprom_ctrl`

## Requirements
- R1: After reset the data-line pull-low enable `sda_oe` is 0 and `busy` is 0.
- R2: Every byte travels most significant bit first. The header byte is 1010 in bits 7..4, the strap value in bits 3..1 and the direction in bit 0 (1 = read). On a match the slave pulls SDA low for the ninth SCL pulse. On a mismatch it leaves SDA released and ignores every later byte until the next START.
- R3: A write header is followed by a high and then a low word-address byte. Only the low ADDR_W bits of the 16-bit word are used, so bit 15 and every other upper bit are ignored. A byte written this way can be read back from the same address.
- R4: The slave acknowledges each data byte of a write. After each byte the low PAGE_W address bits step up by one. From the last byte of a page they wrap to the first byte of the same page, and the upper bits never change.
- R5: A STOP that ends a write holding at least one data byte raises `busy` for exactly max(WR_CYCLES, 2^PAGE_W+1) clocks. A matching header sent while busy gets no acknowledge. The same header is acknowledged once busy has dropped.
- R6: While `wp` is 1, the slave still acknowledges header, address and data bytes, but nothing reaches the array and `busy` stays 0.
- R7: A read started without an address begins at the address after the last byte read or written.
- R8: A read goes on to the next address for as long as the master acknowledges. The address runs from the top of the array back to 0. A byte the master does not acknowledge, followed by STOP, ends the read.
- R9: A STOP that arrives in the middle of a data byte ends the transfer. Nothing is written and `busy` stays 0.
- R10: `sda_oe` changes only while the sampled SCL is low, or right after a START or STOP. It is never 1 during the SCL-high time of a bit that the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap | input | 3 | Device select value compared with header bits 3..1 |
| wp | input | 1 | Write protect, 1 discards buffered write data |
| busy | output | 1 | High while the timed write cycle is running |

## Verification
On every clock, the assertions check that the pull-low enable moves only in SCL-low time or right after a START or STOP. They also check that a header arriving during the write cycle is never acknowledged, that each write cycle lasts exactly the configured number of clocks, that the array is written only inside that window, and that no commit starts while write protect is high. Only the bench scenarios can show what sits in the array: the page wrap order, bit 15 of the address being ignored, the current-address start point, read rollover at the top of the array, and the absence of any change after a protected or aborted write.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // header byte names this slave: type nibble and strap bits both agree
  function automatic logic hdr_hit(input logic [7:0] h, input logic [2:0] sel);
    return (h[7:4] == DEV_TYPE) && (h[3:1] == sel);
  endfunction

  // add one to the low w bits only, keeping the bits above them
  function automatic logic [15:0] wrap_step(input logic [15:0] a, input int unsigned w);
    logic [15:0] m;
    m = 16'((32'd1 << w) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

endpackage

// File: rtl/eeprom_line_sense.sv
module eeprom_line_sense #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [SYNC_N-1:0] scl_sy, sda_sy;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_N-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_N-2:0], sda_i};
      scl_p  <= scl_sy[SYNC_N-1];
      sda_p  <= sda_sy[SYNC_N-1];
    end
  end

  assign scl_s    = scl_sy[SYNC_N-1];
  assign sda_s    = sda_sy[SYNC_N-1];
  assign ev_rise  = scl_s & ~scl_p;
  assign ev_fall  = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned PAGE_W   = 6,
  parameter int unsigned BUSY_CYC = 300
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [PAGE_W-1:0]          widx,
  input  logic [7:0]                 wdata,
  input  logic [ADDR_W-PAGE_W-1:0]   page_in,
  input  logic                       go,
  input  logic                       drop,
  output logic                       any,
  output logic                       busy,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_wa,
  output logic [7:0]                 mem_wd
);
  localparam int unsigned PAGE = 1 << PAGE_W;
  localparam int unsigned PG_W = ADDR_W - PAGE_W;
  localparam int unsigned TW   = $clog2(BUSY_CYC + 1);

  logic [PAGE-1:0]   vld;
  logic [PAGE*8-1:0] dat;
  logic [TW-1:0]     tmr;
  logic              run;
  logic [PAGE_W-1:0] cidx;
  logic [PG_W-1:0]   pg;
  logic              last, clr;

  assign last = run && (cidx == {PAGE_W{1'b1}});
  assign clr  = (drop && !busy && !go) || last;

  // one storage slot per page byte
  for (genvar g = 0; g < PAGE; g++) begin : g_ent
    logic       v_q;
    logic [7:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  v_q <= 1'b0;
      else if (clr)                                v_q <= 1'b0;
      else if (wr && widx == PAGE_W'(g))           v_q <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (wr && widx == PAGE_W'(g)) d_q <= wdata;
    end
    assign vld[g]         = v_q;
    assign dat[g*8 +: 8]  = d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      run  <= 1'b0;
      cidx <= '0;
      pg   <= '0;
    end else if (go) begin
      tmr  <= TW'(BUSY_CYC);
      run  <= 1'b1;
      cidx <= '0;
      pg   <= page_in;
    end else begin
      if (tmr != '0) tmr <= tmr - TW'(1);
      if (run) begin
        cidx <= cidx + PAGE_W'(1);
        if (last) run <= 1'b0;
      end
    end
  end

  assign any    = |vld;
  assign busy   = (tmr != '0);
  assign mem_we = run && vld[cidx];
  assign mem_wa = {pg, cidx};
  assign mem_wd = dat[cidx*8 +: 8];
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rd
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end
  assign rd = mem[ra];
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned WR_CYCLES = 300,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       busy
);
  localparam int unsigned PAGE     = 1 << PAGE_W;
  localparam int unsigned PG_W     = ADDR_W - PAGE_W;
  localparam int unsigned BUSY_CYC = (WR_CYCLES > PAGE + 1) ? WR_CYCLES : PAGE + 1;

  logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;

  phase_t            ph;
  logic [3:0]        bitcnt;
  logic              in_ack, rw, mack, oe_q;
  logic [7:0]        sh, tx, addr_hi, rd_data, mem_wd;
  logic [ADDR_W-1:0] cur, mem_wa;
  logic              pb_any, pb_busy, mem_we;

  // named internal events, also watched by the checker
  logic byte_done, hdr_eval, pb_wr, at_edge, pb_go, pb_drop;
  assign byte_done = ev_fall && !in_ack && (bitcnt == 4'd8);
  assign hdr_eval  = byte_done && (ph == PH_DEV);
  assign pb_wr     = byte_done && (ph == PH_WDAT);
  assign at_edge   = (ph == PH_WDAT) && !in_ack && (bitcnt <= 4'd1);
  assign pb_go     = ev_stop && at_edge && pb_any && !wp;
  assign pb_drop   = ev_start || ev_stop;

  eeprom_line_sense #(.SYNC_N(SYNC_N)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  eeprom_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYC(BUSY_CYC)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .wr(pb_wr), .widx(cur[PAGE_W-1:0]), .wdata(sh),
    .page_in(cur[ADDR_W-1:PAGE_W]), .go(pb_go), .drop(pb_drop), .any(pb_any),
    .busy(pb_busy), .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd)
  );

  eeprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(cur), .rd(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; bitcnt <= '0; in_ack <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      sh <= '0; tx <= '0; addr_hi <= '0; cur <= '0; oe_q <= 1'b0;
    end else if (ev_start) begin
      ph <= PH_DEV; bitcnt <= '0; in_ack <= 1'b0; oe_q <= 1'b0;
    end else if (ev_stop) begin
      ph <= PH_IDLE; bitcnt <= '0; in_ack <= 1'b0; oe_q <= 1'b0;
    end else if (ph == PH_RDAT) begin
      if (ev_rise && !in_ack) begin
        if (bitcnt == 4'd8) begin
          mack   <= ~sda_s;
          in_ack <= 1'b1;
          cur    <= ADDR_W'(wrap_step(16'(cur), ADDR_W));
        end else begin
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (ev_fall && !in_ack) begin
        if (bitcnt == 4'd8) begin
          oe_q <= 1'b0;
        end else if (bitcnt != 4'd0) begin
          tx   <= {tx[6:0], 1'b0};
          oe_q <= ~tx[6];
        end
      end else if (ev_fall && in_ack) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        if (mack) begin
          tx   <= rd_data;
          oe_q <= ~rd_data[7];
        end else begin
          ph   <= PH_IDLE;
          oe_q <= 1'b0;
        end
      end
    end else if (ph != PH_IDLE) begin
      if (ev_rise && !in_ack && bitcnt != 4'd8) begin
        sh     <= {sh[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (byte_done) begin
        case (ph)
          PH_DEV: begin
            if (hdr_hit(sh, strap) && !pb_busy) begin
              in_ack <= 1'b1; oe_q <= 1'b1; rw <= sh[0];
            end else begin
              ph <= PH_IDLE;
            end
          end
          PH_AHI: begin in_ack <= 1'b1; oe_q <= 1'b1; addr_hi <= sh; end
          PH_ALO: begin in_ack <= 1'b1; oe_q <= 1'b1; cur <= ADDR_W'({addr_hi, sh}); end
          default: begin
            in_ack <= 1'b1; oe_q <= 1'b1;
            cur    <= ADDR_W'(wrap_step(16'(cur), PAGE_W));
          end
        endcase
      end else if (ev_fall && in_ack) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        case (ph)
          PH_DEV: begin
            if (rw) begin ph <= PH_RDAT; tx <= rd_data; oe_q <= ~rd_data[7]; end
            else    begin ph <= PH_AHI;  oe_q <= 1'b0; end
          end
          PH_AHI:  begin ph <= PH_ALO;  oe_q <= 1'b0; end
          PH_ALO:  begin ph <= PH_WDAT; oe_q <= 1'b0; end
          default: oe_q <= 1'b0;
        endcase
      end
    end
  end

  assign sda_oe = oe_q;
  assign busy   = pb_busy;
endmodule

// File: rtl/eeprom_ctrl_chk.sv
module eeprom_ctrl_chk #(
  parameter int unsigned BUSY_CYC = 300
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic ev_start,
  input logic ev_stop,
  input logic hdr_eval,
  input logic busy,
  input logic commit_go,
  input logic wp,
  input logic mem_we
);
  logic [31:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 32'd1;
    else           bcnt <= '0;
  end

  // R10: the pull-low enable moves only in SCL-low time or after a bus condition
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(ev_start) || $past(ev_stop)));

  // R5: a header met during the write cycle is never acknowledged
  a_r5_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_eval && busy) |=> !sda_oe);

  // R5: the write cycle lasts exactly the configured count
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BUSY_CYC));

  // R5: array writes happen only inside the write cycle
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6: no commit starts while write protect is high
  a_r6_wp_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !wp);
endmodule

bind eeprom_ctrl eeprom_ctrl_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .ev_start(ev_start), .ev_stop(ev_stop), .hdr_eval(hdr_eval),
  .busy(busy), .commit_go(pb_go), .wp(wp), .mem_we(mem_we)
);

// File: tb/tb_eeprom_ctrl.sv
module tb_eeprom_ctrl;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 6;
  localparam int WR_CYC = 300;
  localparam int AMASK  = (1 << ADDR_W) - 1;
  localparam int PMASK  = (1 << PAGE_W) - 1;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  wire  sda_oe, busy;
  wire  sda_line = m_sda & ~sda_oe;

  eeprom_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .wp(wp), .busy(busy)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit m_owns = 1'b0, no_busy = 1'b0;
  int busy_run = 0, last_len = 0;
  logic [7:0] ref_mem [int];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // per-clock reference comparisons
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_owns)  chk("R10 slave drove a master bit", sda_oe, 0);
      if (no_busy) chk("R6/R9 busy must stay low", busy, 0);
      if (busy) busy_run++;
      else if (busy_run != 0) begin last_len = busy_run; busy_run = 0; end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    scl = 0; wclk(4); m_sda = 1; wclk(4); scl = 1; wclk(6); m_sda = 0; wclk(6); scl = 0;
  endtask

  task automatic i2c_stop;
    scl = 0; wclk(4); m_sda = 0; wclk(4); scl = 1; wclk(6); m_sda = 1; wclk(6);
  endtask

  task automatic send_bit(input logic b);
    scl = 0; wclk(4); m_sda = b; wclk(4); scl = 1; m_owns = 1; wclk(8); m_owns = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    scl = 0; wclk(4); m_sda = 1; wclk(4); scl = 1; wclk(4); ack = !sda_line; wclk(4);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 0; wclk(2); m_sda = 1; wclk(6); scl = 1; wclk(4); b[i] = sda_line; wclk(4);
    end
    scl = 0; wclk(4); m_sda = !mack; wclk(4); scl = 1; m_owns = 1; wclk(8); m_owns = 0;
  endtask

  task automatic wr_seq(input int a, input logic [7:0] d[$], output bit ok);
    bit k;
    ok = 1;
    i2c_start;
    send_byte({4'b1010, STRAP, 1'b0}, k); ok &= k;
    send_byte(a[15:8], k); ok &= k;
    send_byte(a[7:0], k); ok &= k;
    foreach (d[i]) begin send_byte(d[i], k); ok &= k; end
    i2c_stop;
  endtask

  task automatic rd_seq(input int a, input bit rnd, input int n, output logic [7:0] q[$], output bit ok);
    bit k;
    logic [7:0] b;
    ok = 1;
    q = {};
    if (rnd) begin
      i2c_start;
      send_byte({4'b1010, STRAP, 1'b0}, k); ok &= k;
      send_byte(a[15:8], k); ok &= k;
      send_byte(a[7:0], k); ok &= k;
    end
    i2c_start;
    send_byte({4'b1010, STRAP, 1'b1}, k); ok &= k;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      q.push_back(b);
    end
    i2c_stop;
  endtask

  // behavioural model of a committed page write
  function automatic void ref_write(input int a, input logic [7:0] d[$]);
    int x = a & AMASK;
    foreach (d[i]) begin
      ref_mem[x] = d[i];
      x = (x & ~PMASK) | ((x + 1) & PMASK);
    end
  endfunction

  task automatic cmp_reads(input string rq, input int a, input logic [7:0] q[$]);
    foreach (q[i]) chk(rq, q[i], ref_mem[(a + i) & AMASK]);
  endtask

  task automatic wait_free;
    int g = 0;
    while (busy && g < 5000) begin wclk(1); g++; end
    wclk(4);
  endtask

  initial begin
    bit ok, k;
    logic [7:0] q[$];
    logic [7:0] d[$];

    wclk(5);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 busy after reset", busy, 0);
    rst_n = 1; wclk(5);

    // R2: wrong strap value gets no acknowledge, later bytes ignored too
    i2c_start;
    send_byte({4'b1010, 3'b001, 1'b0}, k); chk("R2 mismatch header nack", k, 0);
    send_byte(8'h00, k);                   chk("R2 byte after mismatch ignored", k, 0);
    i2c_stop;
    i2c_start;
    send_byte({4'b0110, STRAP, 1'b0}, k);  chk("R2 wrong type nibble nack", k, 0);
    i2c_stop;

    // R3: bit 15 of the word address is ignored; two-byte write
    d = '{8'h5A, 8'hC3};
    last_len = 0;
    wr_seq(16'h8123, d, ok); chk("R2/R3 write acks", ok, 1);
    ref_write(16'h8123, d);
    wait_free;
    chk("R5 busy length", last_len, WR_CYC);
    rd_seq(16'h0123, 1, 1, q, ok); chk("R3 random read acks", ok, 1);
    cmp_reads("R3 read back", 16'h0123, q);

    // R7: current-address read continues after the byte just read
    rd_seq(0, 0, 1, q, ok); chk("R7 current read ack", ok, 1);
    cmp_reads("R7 current address data", 16'h0124, q);

    // R4: page write that wraps inside its page; R5 polling during busy
    d = '{8'hAA, 8'hAB, 8'hAC, 8'hAD, 8'hAE, 8'hAF};
    wr_seq(16'h01FC, d, ok); chk("R4 page write acks", ok, 1);
    ref_write(16'h01FC, d);
    chk("R5 busy after stop", busy, 1);
    i2c_start;
    send_byte({4'b1010, STRAP, 1'b0}, k); chk("R5 header nack while busy", k, 0);
    i2c_stop;
    wait_free;
    i2c_start;
    send_byte({4'b1010, STRAP, 1'b0}, k); chk("R5 header ack after busy", k, 1);
    i2c_stop;
    rd_seq(16'h01FC, 1, 4, q, ok); chk("R8 sequential read acks", ok, 1);
    cmp_reads("R4 page tail", 16'h01FC, q);
    rd_seq(16'h01C0, 1, 2, q, ok);
    cmp_reads("R4 wrapped bytes at page start", 16'h01C0, q);

    // R8: read rollover from the top of the array to address 0
    d = '{8'h11, 8'h22};
    wr_seq(16'h03FE, d, ok); ref_write(16'h03FE, d); wait_free;
    d = '{8'h33};
    wr_seq(16'h0000, d, ok); ref_write(16'h0000, d); wait_free;
    rd_seq(16'h03FE, 1, 3, q, ok);
    chk("R8 rollover byte count", q.size(), 3);
    cmp_reads("R8 rollover data", 16'h03FE, q);

    // R6: write protect keeps acks but stores nothing and stays idle
    wp = 1; no_busy = 1;
    d = '{8'hEE};
    wr_seq(16'h0123, d, ok); chk("R6 acks under write protect", ok, 1);
    wclk(400);
    no_busy = 0; wp = 0;
    rd_seq(16'h0123, 1, 1, q, ok);
    cmp_reads("R6 data unchanged", 16'h0123, q);

    // R9: STOP in the middle of a data byte aborts the write
    no_busy = 1;
    i2c_start;
    send_byte({4'b1010, STRAP, 1'b0}, k);
    send_byte(8'h01, k);
    send_byte(8'h23, k);
    for (int i = 7; i >= 4; i--) send_bit(i[0]);
    i2c_stop;
    wclk(400);
    no_busy = 0;
    rd_seq(16'h0123, 1, 1, q, ok);
    cmp_reads("R9 aborted write left data", 16'h0123, q);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1-timeout actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule